// File: doc/BRIEF.md
# I2C Bus Time-out Monitor

This block sits beside an I2C host engine and watches the clock line together with the protocol event strobes the engine produces (START, acknowledge and STOP). It runs four independent timers from a shared prescaled microsecond tick. The first measures one continuous stretch of the clock being held low. The second measures how long the bus has been inactive, meaning the clock is held low by either side. The third sums all low time over a whole transfer, from START to STOP. The fourth sums low time inside each protocol segment: START to acknowledge, acknowledge to acknowledge, or acknowledge to STOP.

When the continuous-low timer or either summing timer runs out, the monitor raises a single-cycle abort request. The host engine responds by releasing its clock hold, finishing the transfer and sending an automatic STOP. The monitor also sets sticky status flags that software clears by writing ones. When the inactive-bus timer runs out, the monitor pulses a force-idle signal so the engine's bus-state logic returns to idle. Configuration is captured only while the monitor is disabled, so a running monitor sees stable thresholds.

Top module: `i2c_bus_tmo_mon`

## Requirements
- R1: After reset, `abort_req` and `force_idle` are 0 and `sts` is 3'b000.
- R2: With `mon_en` and `cfg_low_en` set, once `scl_in` has been low on LOW_TICKS consecutive tick cycles, `abort_req` is high for exactly one cycle. The pulse starts after the clock edge that samples the last of those ticks. A cycle with `scl_in` high restarts the count.
- R3: A continuous-low abort sets `sts[0]` (low time-out) and `sts[2]` (bus error) on the clock edge that ends the abort pulse.
- R4: `cfg_inact_sel` chooses the inactive-bus limit: 0 disables it, 1 gives 5, 2 gives 10 and 3 gives 20 units of INACT_UNIT_TICKS ticks. Once `scl_in` has been low for that many consecutive ticks, `force_idle` pulses for one cycle. This neither raises `abort_req` nor sets any status bit.
- R5: With `cfg_cext_en` set, low ticks are summed while a transfer is open, across high gaps and acknowledges. A transfer opens at `evt_start` and closes at `evt_stop`. The sum restarts at every START and STOP. When it reaches CEXT_TICKS, `abort_req` pulses for one cycle.
- R6: With `cfg_hext_en` set, low ticks inside an open transfer are summed. The sum restarts at each START, acknowledge and STOP. When it reaches HEXT_TICKS, `abort_req` pulses for one cycle.
- R7: An abort from either summing timer sets `sts[1]` (extension time-out) and `sts[2]` (bus error) on the edge that ends the abort pulse.
- R8: Timers advance only on cycles where `tick_1us` is high. An event that restarts a sum wins over a tick in the same cycle.
- R9: Each timer pulses at most once. It then holds until it is restarted, so a clock that stays low produces no further pulses.
- R10: Status bits stay set until a 1 is written to the matching `sts_clr` bit. A set and a clear in the same cycle leave the bit set.
- R11: Configuration inputs are captured only on cycles where `mon_en` is low. Changes made while enabled have no effect. Dropping `mon_en` for one cycle restarts every timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1us | input | 1 | Prescaled time tick, one cycle per microsecond |
| scl_in | input | 1 | Sampled clock line level |
| evt_start | input | 1 | START seen strobe |
| evt_ack | input | 1 | Acknowledge bit seen strobe |
| evt_stop | input | 1 | STOP seen strobe |
| mon_en | input | 1 | Monitor enable |
| cfg_low_en | input | 1 | Enable continuous-low time-out |
| cfg_inact_sel | input | 2 | Inactive-bus limit select |
| cfg_cext_en | input | 1 | Enable whole-transfer summing time-out |
| cfg_hext_en | input | 1 | Enable per-segment summing time-out |
| sts_clr | input | 3 | Write-one-to-clear for status bits |
| abort_req | output | 1 | Release hold, finish transfer and send STOP (one-cycle pulse) |
| force_idle | output | 1 | Force bus state to idle (one-cycle pulse) |
| sts | output | 3 | Sticky status: [0] low time-out, [1] extension time-out, [2] bus error |

## Verification
The assertions check, on every cycle, properties that hold locally. Every expiry is a single-cycle pulse that follows a sampled tick, and no counter passes its limit. Every abort sets its flags on the next edge. A set status bit only drops when it is written with a 1. The captured configuration does not move while the monitor runs. Transfer open and close follow the START and STOP strobes. The bench scenarios show the rest: the exact expiry cycle for each limit and inactive setting, that sums carry across high gaps but restart at the right events, that a restart wins over a tick in the same cycle, and that configuration writes are ignored while enabled.

// File: rtl/i2c_tmo_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the I2C bus time-out monitor.
// Assumes four timers in a fixed index order used by the top level.
package i2c_tmo_pkg;

    localparam int NUM_TMR   = 4;
    localparam int TMR_LOW   = 0;
    localparam int TMR_INACT = 1;
    localparam int TMR_CEXT  = 2;
    localparam int TMR_HEXT  = 3;

    localparam int ST_LOW    = 0;
    localparam int ST_EXT    = 1;
    localparam int ST_BUSERR = 2;
    localparam int ST_W      = 3;

    typedef struct packed {
        logic       low_en;
        logic [1:0] inact_sel;
        logic       cext_en;
        logic       hext_en;
    } tmo_cfg_t;

    // Number of inactive-bus units selected by the 2-bit field.
    function automatic int unsigned inact_mult(input logic [1:0] sel);
        case (sel)
            2'd1:    return 5;
            2'd2:    return 10;
            2'd3:    return 20;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/i2c_tmo_counter.sv
`timescale 1ns/1ps
// Saturating tick counter with a runtime limit.
// It counts sampled ticks while run is high and pulses expire for one cycle
// when the count reaches thr. It then holds until clear or deactivation.
// Assumes thr only changes while active is low. A limit of 0 never fires.
module i2c_tmo_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             active,
    input  logic             clear,
    input  logic             run,
    input  logic [CNT_W-1:0] thr,
    output logic             expire
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_inc;

    // Next count value when a tick is taken.
    always_comb begin
        cnt_inc = cnt + CNT_W'(1);
    end

    // Count, saturate at the limit and raise a one-cycle expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (!active || clear) begin
                cnt <= '0;
            end else if (run && tick && (cnt < thr)) begin
                cnt    <= cnt_inc;
                expire <= (cnt_inc == thr);
            end
        end
    end

    // R9: expiry never lasts more than one cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);

    // R8: an expiry only follows a sampled tick while running
    a_r8_expire_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> $past(tick && run && active && !clear));

    // R9: the count never passes its limit
    a_r9_no_overshoot: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= thr);

endmodule

// File: rtl/i2c_tmo_cfg_shadow.sv
`timescale 1ns/1ps
// Configuration capture for the time-out monitor.
// It copies the live configuration only while the monitor is disabled,
// so the timers see frozen settings while running.
module i2c_tmo_cfg_shadow
    import i2c_tmo_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  tmo_cfg_t cfg_in,
    output tmo_cfg_t cfg_q
);

    // Capture settings on disabled cycles only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (!en) begin
            cfg_q <= cfg_in;
        end
    end

    // R11: settings stay frozen after a cycle with the monitor enabled
    a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en) |-> $stable(cfg_q));

endmodule

// File: rtl/i2c_tmo_seg_track.sv
`timescale 1ns/1ps
// Transfer and segment tracker.
// It keeps an open-transfer flag from START to STOP and builds the restart
// strobes for the two summing timers. Assumes one-cycle event strobes;
// START wins if START and STOP share a cycle.
module i2c_tmo_seg_track (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic start,
    input  logic ack,
    input  logic stop,
    output logic in_xfer,
    output logic client_clr,
    output logic host_clr
);

    // Open-transfer flag, cleared while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_xfer <= 1'b0;
        end else if (!en) begin
            in_xfer <= 1'b0;
        end else if (start) begin
            in_xfer <= 1'b1;
        end else if (stop) begin
            in_xfer <= 1'b0;
        end
    end

    // Restart strobes: whole-transfer sum and per-segment sum.
    always_comb begin
        client_clr = start | stop;
        host_clr   = start | ack | stop;
    end

    // R5: a START opens the transfer
    a_r5_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (en && start) |=> in_xfer);

    // R5: a STOP alone closes the transfer
    a_r5_stop_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start) |=> !in_xfer);

endmodule

// File: rtl/i2c_tmo_status.sv
`timescale 1ns/1ps
// Sticky status register with write-one-to-clear.
// A set in the same cycle as a clear wins.
module i2c_tmo_status #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] sts
);

    // Hold, clear on ones written, then apply new sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts <= '0;
        end else begin
            sts <= (sts & ~clr) | set;
        end
    end

    // R10: every requested set is visible on the next cycle
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((sts & $past(set)) == $past(set)));

    // R10: bits not written with one stay set
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts & ~clr) != '0) |=> ((($past(sts) & ~$past(clr)) & ~sts) == '0));

endmodule

// File: rtl/i2c_bus_tmo_mon.sv
`timescale 1ns/1ps
// I2C bus time-out monitor, top level.
// It runs four tick-based timers: continuous low, inactive bus, whole-transfer
// low sum and per-segment low sum. Expiries become a one-cycle abort request or
// force-idle pulse, and sticky status flags record them.
// Assumes tick_1us is a one-cycle strobe and scl_in is already synchronised.
module i2c_bus_tmo_mon
    import i2c_tmo_pkg::*;
#(
    parameter int LOW_TICKS        = 25000,
    parameter int CEXT_TICKS       = 25000,
    parameter int HEXT_TICKS       = 10000,
    parameter int INACT_UNIT_TICKS = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1us,
    input  logic       scl_in,
    input  logic       evt_start,
    input  logic       evt_ack,
    input  logic       evt_stop,
    input  logic       mon_en,
    input  logic       cfg_low_en,
    input  logic [1:0] cfg_inact_sel,
    input  logic       cfg_cext_en,
    input  logic       cfg_hext_en,
    input  logic [2:0] sts_clr,
    output logic       abort_req,
    output logic       force_idle,
    output logic [2:0] sts
);

    localparam int MAX_A = (LOW_TICKS > CEXT_TICKS) ? LOW_TICKS : CEXT_TICKS;
    localparam int MAX_B = (HEXT_TICKS > 20 * INACT_UNIT_TICKS) ? HEXT_TICKS : 20 * INACT_UNIT_TICKS;
    localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = $clog2(MAX_T + 1);

    tmo_cfg_t cfg_live;
    tmo_cfg_t cfg_q;
    logic     in_xfer;
    logic     client_clr;
    logic     host_clr;

    logic [NUM_TMR-1:0] tmr_act;
    logic [NUM_TMR-1:0] tmr_clr;
    logic [NUM_TMR-1:0] tmr_run;
    logic [NUM_TMR-1:0] tmr_exp;
    logic [CNT_W-1:0]   tmr_thr [NUM_TMR];
    logic [ST_W-1:0]    sts_set;

    // Pack the live configuration fields.
    always_comb begin
        cfg_live.low_en    = cfg_low_en;
        cfg_live.inact_sel = cfg_inact_sel;
        cfg_live.cext_en   = cfg_cext_en;
        cfg_live.hext_en   = cfg_hext_en;
    end

    i2c_tmo_cfg_shadow u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (mon_en),
        .cfg_in (cfg_live),
        .cfg_q  (cfg_q)
    );

    i2c_tmo_seg_track u_seg (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (mon_en),
        .start      (evt_start),
        .ack        (evt_ack),
        .stop       (evt_stop),
        .in_xfer    (in_xfer),
        .client_clr (client_clr),
        .host_clr   (host_clr)
    );

    // Timer controls: activation, restart, run condition and limit.
    always_comb begin
        tmr_act[TMR_LOW]   = mon_en & cfg_q.low_en;
        tmr_clr[TMR_LOW]   = scl_in;
        tmr_run[TMR_LOW]   = ~scl_in;
        tmr_thr[TMR_LOW]   = CNT_W'(LOW_TICKS);

        tmr_act[TMR_INACT] = mon_en & (cfg_q.inact_sel != 2'd0);
        tmr_clr[TMR_INACT] = scl_in;
        tmr_run[TMR_INACT] = ~scl_in;
        tmr_thr[TMR_INACT] = CNT_W'(inact_mult(cfg_q.inact_sel) * INACT_UNIT_TICKS);

        tmr_act[TMR_CEXT]  = mon_en & cfg_q.cext_en;
        tmr_clr[TMR_CEXT]  = client_clr;
        tmr_run[TMR_CEXT]  = ~scl_in & in_xfer;
        tmr_thr[TMR_CEXT]  = CNT_W'(CEXT_TICKS);

        tmr_act[TMR_HEXT]  = mon_en & cfg_q.hext_en;
        tmr_clr[TMR_HEXT]  = host_clr;
        tmr_run[TMR_HEXT]  = ~scl_in & in_xfer;
        tmr_thr[TMR_HEXT]  = CNT_W'(HEXT_TICKS);
    end

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        i2c_tmo_counter #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick_1us),
            .active (tmr_act[g]),
            .clear  (tmr_clr[g]),
            .run    (tmr_run[g]),
            .thr    (tmr_thr[g]),
            .expire (tmr_exp[g])
        );
    end

    // Route expiries to the engine requests and to the status sets.
    always_comb begin
        abort_req           = tmr_exp[TMR_LOW] | tmr_exp[TMR_CEXT] | tmr_exp[TMR_HEXT];
        force_idle          = tmr_exp[TMR_INACT];
        sts_set[ST_LOW]     = tmr_exp[TMR_LOW];
        sts_set[ST_EXT]     = tmr_exp[TMR_CEXT] | tmr_exp[TMR_HEXT];
        sts_set[ST_BUSERR]  = abort_req;
    end

    i2c_tmo_status #(
        .W (ST_W)
    ) u_sts (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (sts_set),
        .clr   (sts_clr),
        .sts   (sts)
    );

    // R3: a continuous-low expiry raises low and bus-error flags
    a_r3_low_flags: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_exp[TMR_LOW] |=> (sts[ST_LOW] && sts[ST_BUSERR]));

    // R7: a summing expiry raises extension and bus-error flags
    a_r7_ext_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_exp[TMR_CEXT] || tmr_exp[TMR_HEXT]) |=> (sts[ST_EXT] && sts[ST_BUSERR]));

    // R2: an abort only follows a cycle with the clock sampled low
    a_r2_abort_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |-> $past(!scl_in));

    // R4: force-idle only follows a cycle with the clock sampled low
    a_r4_idle_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        force_idle |-> $past(!scl_in));

endmodule

// File: tb/i2c_bus_tmo_mon_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected pulses, and the monitor pops and compares them.
module i2c_bus_tmo_mon_tb;

    localparam int LOW_T  = 20;
    localparam int CEXT_T = 50;
    localparam int HEXT_T = 16;
    localparam int UNIT_T = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       scl = 1'b1;
    logic       ev_start = 1'b0;
    logic       ev_ack = 1'b0;
    logic       ev_stop = 1'b0;
    logic       en = 1'b0;
    logic       c_low = 1'b0;
    logic [1:0] c_sel = 2'd0;
    logic       c_cext = 1'b0;
    logic       c_hext = 1'b0;
    logic [2:0] sclr = 3'd0;
    logic       abort_req;
    logic       force_idle;
    logic [2:0] sts;

    int unsigned cyc = 0;
    int          checks = 0;
    int          errors = 0;

    typedef struct {
        int unsigned at;
        logic [1:0]  code;
        string       req;
    } exp_t;
    exp_t sb_q[$];

    i2c_bus_tmo_mon #(
        .LOW_TICKS        (LOW_T),
        .CEXT_TICKS       (CEXT_T),
        .HEXT_TICKS       (HEXT_T),
        .INACT_UNIT_TICKS (UNIT_T)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_1us      (tick),
        .scl_in        (scl),
        .evt_start     (ev_start),
        .evt_ack       (ev_ack),
        .evt_stop      (ev_stop),
        .mon_en        (en),
        .cfg_low_en    (c_low),
        .cfg_inact_sel (c_sel),
        .cfg_cext_en   (c_cext),
        .cfg_hext_en   (c_hext),
        .sts_clr       (sclr),
        .abort_req     (abort_req),
        .force_idle    (force_idle),
        .sts           (sts)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Code 2'b01 = abort pulse, 2'b10 = force-idle pulse, dly counted from now.
    task automatic expect_pulse(input logic [1:0] code, input int unsigned dly, input string req);
        exp_t e;
        e.at = cyc + dly;
        e.code = code;
        e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic configure(input logic lo, input logic [1:0] sel, input logic ce, input logic he);
        en = 1'b0; c_low = lo; c_sel = sel; c_cext = ce; c_hext = he;
        step(1);
        en = 1'b1;
        step(1);
    endtask

    task automatic clear_sts();
        sclr = 3'b111;
        step(1);
        sclr = 3'b000;
    endtask

    task automatic pulse_start();
        ev_start = 1'b1; step(1); ev_start = 1'b0;
    endtask

    task automatic pulse_ack();
        ev_ack = 1'b1; step(1); ev_ack = 1'b0;
    endtask

    task automatic pulse_stop();
        ev_stop = 1'b1; step(1); ev_stop = 1'b0;
    endtask

    // Monitor: every observed pulse must match the head of the queue.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && (abort_req || force_idle)) begin
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL R9 unexpected pulse: actual code=%b cycle %0d, expected none",
                         {force_idle, abort_req}, cyc);
            end else begin
                e = sb_q.pop_front();
                if (e.at != cyc || e.code != {force_idle, abort_req}) begin
                    errors++;
                    $display("FAIL %s pulse: actual code=%b cycle %0d, expected code=%b cycle %0d",
                             e.req, {force_idle, abort_req}, cyc, e.code, e.at);
                end
            end
        end
    end

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        step(3);
        chk("R1", "abort in reset", {31'd0, abort_req}, 0);
        chk("R1", "sts in reset", {29'd0, sts}, 0);
        rst_n = 1'b1;
        step(2);
        chk("R1", "idle after reset", {29'd0, force_idle, abort_req, 1'b0}, 0);
        chk("R1", "sts after reset", {29'd0, sts}, 0);

        // R2: continuous low with a restart in the middle
        configure(1'b1, 2'd0, 1'b0, 1'b0);
        scl = 1'b0; step(10);
        scl = 1'b1; step(1);
        scl = 1'b0;
        expect_pulse(2'b01, LOW_T, "R2");
        step(LOW_T);
        chk("R3", "sts during pulse", {29'd0, sts}, 0);
        step(1);
        chk("R3", "sts after low abort", {29'd0, sts}, 32'h5);
        step(10);
        chk("R10", "sts sticky", {29'd0, sts}, 32'h5);
        scl = 1'b1; step(1);
        clear_sts();
        chk("R10", "sts cleared", {29'd0, sts}, 0);

        // R10: set wins over a clear in the same cycle
        scl = 1'b0;
        expect_pulse(2'b01, LOW_T, "R2");
        step(LOW_T);
        sclr = 3'b111; step(1); sclr = 3'b000;
        chk("R10", "set wins over clear", {29'd0, sts}, 32'h5);
        scl = 1'b1; step(1);
        clear_sts();

        // R11: config change while enabled is ignored
        c_low = 1'b0;
        scl = 1'b0;
        expect_pulse(2'b01, LOW_T, "R11");
        step(LOW_T + 2);
        scl = 1'b1; step(1);
        chk("R11", "low still active", {29'd0, sts}, 32'h5);
        clear_sts();

        // R8: ticks on every other cycle
        configure(1'b1, 2'd0, 1'b0, 1'b0);
        scl = 1'b0;
        expect_pulse(2'b01, 2 * LOW_T - 1, "R8");
        for (int i = 0; i < 2 * LOW_T; i++) begin
            tick = (i % 2 == 0);
            step(1);
        end
        tick = 1'b1;
        scl = 1'b1; step(1);
        clear_sts();

        // R11: dropping enable restarts the timers
        scl = 1'b0; step(15);
        en = 1'b0; step(1);
        en = 1'b1;
        expect_pulse(2'b01, LOW_T, "R11");
        step(LOW_T + 2);
        scl = 1'b1; step(1);
        clear_sts();

        // R11: low timer disabled after capture while off
        configure(1'b0, 2'd0, 1'b0, 1'b0);
        scl = 1'b0; step(LOW_T + 10);
        scl = 1'b1; step(2);
        chk("R11", "low disabled", {29'd0, sts}, 0);

        // R4: inactive limits 5/10/20 units
        for (int s = 1; s < 4; s++) begin
            configure(1'b0, 2'(s), 1'b0, 1'b0);
            scl = 1'b0;
            expect_pulse(2'b10, (s == 1 ? 5 : (s == 2 ? 10 : 20)) * UNIT_T, "R4");
            step(20 * UNIT_T + 3);
            scl = 1'b1; step(1);
        end
        chk("R4", "no status from inactive", {29'd0, sts}, 0);
        configure(1'b0, 2'd0, 1'b0, 1'b0);
        scl = 1'b0; step(20 * UNIT_T + 5);
        scl = 1'b1; step(1);
        chk("R4", "sel 0 disabled", {29'd0, sts}, 0);

        // R5: whole-transfer sum across gaps and acknowledges
        configure(1'b0, 2'd0, 1'b1, 1'b0);
        pulse_start();
        scl = 1'b0; step(20);
        scl = 1'b1; pulse_ack(); step(4);
        scl = 1'b0; step(20);
        scl = 1'b1; step(5);
        scl = 1'b0;
        expect_pulse(2'b01, CEXT_T - 40, "R5");
        step(CEXT_T - 40 + 2);
        scl = 1'b1; step(1);
        chk("R7", "sts after client abort", {29'd0, sts}, 32'h6);
        clear_sts();
        pulse_stop();
        // R5: a new START restarts the sum
        pulse_start();
        scl = 1'b0; step(30);
        scl = 1'b1; pulse_start();
        scl = 1'b0; step(30);
        scl = 1'b1; pulse_stop();
        // R5: no summing outside a transfer
        scl = 1'b0; step(CEXT_T + 5);
        scl = 1'b1; step(1);
        chk("R5", "start/stop restart sum", {29'd0, sts}, 0);

        // R6: per-segment sum restarted by acknowledges
        configure(1'b0, 2'd0, 1'b0, 1'b1);
        pulse_start();
        scl = 1'b0; step(10);
        scl = 1'b1; pulse_ack();
        scl = 1'b0; step(10);
        scl = 1'b1; pulse_ack();
        chk("R6", "segments below limit", {29'd0, sts}, 0);
        scl = 1'b0; step(10);
        scl = 1'b1; step(2);
        scl = 1'b0;
        expect_pulse(2'b01, HEXT_T - 10, "R6");
        step(HEXT_T - 10 + 2);
        scl = 1'b1; step(1);
        chk("R7", "sts after host abort", {29'd0, sts}, 32'h6);
        clear_sts();

        // R8: acknowledge with clock low wins over that cycle's tick
        pulse_ack();
        scl = 1'b0; step(15);
        ev_ack = 1'b1; step(1); ev_ack = 1'b0;
        expect_pulse(2'b01, HEXT_T, "R8");
        step(HEXT_T + 2);
        scl = 1'b1; pulse_stop();
        step(3);

        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL %s missing pulses: actual=%0d expected=0", sb_q[0].req, sb_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule